// File: doc/BRIEF.md
# Coarse-to-fine search sequencer

This controller steers a correlation search engine through an image pyramid and a target pyramid that have the same number of levels. After a start pulse it begins at the coarsest level. There the engine is asked to search every placement of the target inside the image. The answer becomes a tentative position. The sequencer then steps one level finer, doubles that position and asks the engine to search only a narrow band around it. This repeats until the full-resolution level has been searched. That last answer is reported as the final row and column, and a done flag is raised.

The sizes of the image and the target at each level arrive as flat vectors, one field of `DIM_W` bits per level, with level 0 in the lowest field. Each search command carries the level and inclusive bounds for the target's top-left corner. The command is held until the engine accepts it. The engine later returns its best row and column with a one-cycle response strobe.

Top module: `pyr_search_seq`

## Requirements
- R1: After reset, `done` and `cmd_valid` are low and `final_row`/`final_col` are zero.
- R2: A start pulse taken while idle issues a first command on the next cycle at level `num_levels-1`. Its window is rows 0..L_r and columns 0..L_c, where L_r = image height minus target height and L_c = image width minus target width at that level. A `num_levels` of 0 is treated as 1, and a value above `MAX_LEVELS` is treated as `MAX_LEVELS`.
- R3: When the target is larger than the image along an axis at some level, the limit along that axis is 0, and the window bounds there never exceed 0.
- R4: Each response received at a level above 0 issues a command at the next lower level on the next cycle. For seed s = 2 × response, along each axis lo = max(s − MARGIN, 0) and hi = min(s + MARGIN, L), where L is that level's limit. If lo would exceed hi, lo is set to hi.
- R5: `cmd_valid` stays high with level and bounds unchanged until the cycle in which `cmd_ready` is high. It then drops. No further command appears until the engine has responded, so each level gets exactly one command.
- R6: `rsp_valid` has no effect while a command is still waiting to be accepted.
- R7: The response at level 0 raises `done` on the next cycle, loads `final_row`/`final_col` with that response, and issues no further command.
- R8: A start pulse during a running sequence is ignored: the sequence of levels and windows continues unchanged.
- R9: `done` stays high until the next accepted start, and drops on the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search sequence (taken only when idle) |
| num_levels | input | $clog2(MAX_LEVELS+1) | Number of pyramid levels to walk |
| img_w_all | input | MAX_LEVELS*DIM_W | Image width per level, level 0 in the low field |
| img_h_all | input | MAX_LEVELS*DIM_W | Image height per level |
| tgt_w_all | input | MAX_LEVELS*DIM_W | Target width per level |
| tgt_h_all | input | MAX_LEVELS*DIM_W | Target height per level |
| cmd_valid | output | 1 | Search command pending |
| cmd_ready | input | 1 | Engine accepts the pending command |
| cmd_level | output | LVL_W | Pyramid level of the command |
| cmd_row_lo | output | DIM_W | Lowest row to try |
| cmd_row_hi | output | DIM_W | Highest row to try |
| cmd_col_lo | output | DIM_W | Lowest column to try |
| cmd_col_hi | output | DIM_W | Highest column to try |
| rsp_valid | input | 1 | Engine result strobe |
| rsp_row | input | DIM_W | Best row found by the engine |
| rsp_col | input | DIM_W | Best column found by the engine |
| done | output | 1 | Sequence finished, final position valid |
| final_row | output | DIM_W | Full-resolution row of the match |
| final_col | output | DIM_W | Full-resolution column of the match |

## Verification
The bench builds the block with `MAX_LEVELS`=5, `DIM_W`=10 and `MARGIN`=2. Five levels with a 3-bit level count make the clamp of `num_levels` values 6 and 7 reachable. They also leave three unused select slots in the level multiplexer. Ten-bit coordinates up to 1023 let a doubled seed run past the limit at the finer level, which exercises the clipping of both bounds. Directed cases cover a target taller than its image at the coarsest level, a level count of zero, and responses pinned to the upper window edge.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // strobes from the sequencing FSM to the datapath
    typedef struct packed {
        logic load;    // latch a new window
        logic first;   // window is the full coarsest-level span
        logic finish;  // latch final position
    } seq_ctl_t;

    // largest top-left coordinate at which the target still fits
    function automatic logic [31:0] fit_limit(input logic [31:0] img,
                                              input logic [31:0] tgt);
        return (img >= tgt) ? (img - tgt) : 32'd0;
    endfunction

    function automatic logic [31:0] band_lo(input logic [31:0] centre,
                                            input logic [31:0] margin,
                                            input logic [31:0] lim);
        logic [31:0] t;
        t = (centre > margin) ? (centre - margin) : 32'd0;
        return (t > lim) ? lim : t;
    endfunction

    function automatic logic [31:0] band_hi(input logic [31:0] centre,
                                            input logic [31:0] margin,
                                            input logic [31:0] lim);
        logic [31:0] t;
        t = centre + margin;
        return (t < lim) ? t : lim;
    endfunction

endpackage

// File: rtl/pss_level_mux.sv
module pss_level_mux
    import pss_pkg::*;
#(
    parameter int MAX_LEVELS = 4,
    parameter int DIM_W      = 10,
    parameter int LVL_W      = 2
) (
    input  logic [LVL_W-1:0]            sel,
    input  logic [MAX_LEVELS*DIM_W-1:0] img_w_all,
    input  logic [MAX_LEVELS*DIM_W-1:0] img_h_all,
    input  logic [MAX_LEVELS*DIM_W-1:0] tgt_w_all,
    input  logic [MAX_LEVELS*DIM_W-1:0] tgt_h_all,
    output logic [1:0][DIM_W-1:0]       lim        // [0] row axis, [1] column axis
);
    localparam int SLOTS = 1 << LVL_W;

    logic [DIM_W-1:0] iw [SLOTS];
    logic [DIM_W-1:0] ih [SLOTS];
    logic [DIM_W-1:0] tw [SLOTS];
    logic [DIM_W-1:0] th [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < MAX_LEVELS) begin : g_used
            assign iw[i] = img_w_all[i*DIM_W +: DIM_W];
            assign ih[i] = img_h_all[i*DIM_W +: DIM_W];
            assign tw[i] = tgt_w_all[i*DIM_W +: DIM_W];
            assign th[i] = tgt_h_all[i*DIM_W +: DIM_W];
        end else begin : g_pad
            assign iw[i] = '0;
            assign ih[i] = '0;
            assign tw[i] = '0;
            assign th[i] = '0;
        end
    end

    assign lim[0] = DIM_W'(fit_limit(32'(ih[sel]), 32'(th[sel])));
    assign lim[1] = DIM_W'(fit_limit(32'(iw[sel]), 32'(tw[sel])));

endmodule

// File: rtl/pss_window.sv
module pss_window
    import pss_pkg::*;
#(
    parameter int DIM_W  = 10,
    parameter int MARGIN = 2
) (
    input  logic                  first,
    input  logic [1:0][DIM_W-1:0] lim,
    input  logic [1:0][DIM_W-1:0] seed,
    output logic [1:0][DIM_W-1:0] lo,
    output logic [1:0][DIM_W-1:0] hi
);
    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [DIM_W:0] dbl;
        assign dbl   = {seed[a], 1'b0};
        assign lo[a] = first ? '0
                     : DIM_W'(band_lo(32'(dbl), 32'(MARGIN), 32'(lim[a])));
        assign hi[a] = first ? lim[a]
                     : DIM_W'(band_hi(32'(dbl), 32'(MARGIN), 32'(lim[a])));
    end
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
    import pss_pkg::*;
#(
    parameter int MAX_LEVELS = 4,
    parameter int NUM_W      = 3,
    parameter int LVL_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num_levels,
    input  logic             cmd_ready,
    input  logic             rsp_valid,
    output logic             cmd_valid,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] nxt_level,
    output seq_ctl_t         ctl,
    output logic             done
);
    seq_state_e       state_q, state_d;
    logic [LVL_W-1:0] level_q;
    logic [NUM_W-1:0] n_eff;
    logic [LVL_W-1:0] top_lvl;

    always_comb begin
        if (num_levels == '0)
            n_eff = NUM_W'(1);
        else if (num_levels > NUM_W'(MAX_LEVELS))
            n_eff = NUM_W'(MAX_LEVELS);
        else
            n_eff = num_levels;
    end
    assign top_lvl = LVL_W'(n_eff - NUM_W'(1));

    always_comb begin
        state_d    = state_q;
        nxt_level  = level_q;
        ctl        = '0;
        case (state_q)
            SEQ_IDLE: if (start) begin
                state_d   = SEQ_ISSUE;
                nxt_level = top_lvl;
                ctl.load  = 1'b1;
                ctl.first = 1'b1;
            end
            SEQ_ISSUE: if (cmd_ready) state_d = SEQ_WAIT;
            SEQ_WAIT: if (rsp_valid) begin
                if (level_q == '0) begin
                    state_d    = SEQ_IDLE;
                    ctl.finish = 1'b1;
                end else begin
                    state_d   = SEQ_ISSUE;
                    nxt_level = level_q - LVL_W'(1);
                    ctl.load  = 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            level_q <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= nxt_level;
            if (state_q == SEQ_IDLE && start)
                done <= 1'b0;
            else if (ctl.finish)
                done <= 1'b1;
        end
    end

    assign cmd_valid = (state_q == SEQ_ISSUE);
    assign level     = level_q;

    // R4: each refinement moves exactly one level finer
    p_level_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_WAIT && rsp_valid && level_q != '0)
        |=> (level_q == LVL_W'($past(level_q) - LVL_W'(1))));

    // R6: a response strobe while the command is unaccepted changes nothing
    p_rsp_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_ISSUE && !cmd_ready)
        |=> (state_q == SEQ_ISSUE && $stable(level_q)));

    // R8: start during a running sequence leaves the level untouched
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE && start && !(state_q == SEQ_WAIT && rsp_valid))
        |=> $stable(level_q));

    // R9: done holds until a start, and drops after an accepted start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && start) |=> !done);

endmodule

// File: rtl/pyr_search_seq.sv
module pyr_search_seq
    import pss_pkg::*;
#(
    parameter int MAX_LEVELS = 4,
    parameter int DIM_W      = 10,
    parameter int MARGIN     = 2,
    localparam int NUM_W     = $clog2(MAX_LEVELS + 1),
    localparam int LVL_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [NUM_W-1:0]            num_levels,
    input  logic [MAX_LEVELS*DIM_W-1:0] img_w_all,
    input  logic [MAX_LEVELS*DIM_W-1:0] img_h_all,
    input  logic [MAX_LEVELS*DIM_W-1:0] tgt_w_all,
    input  logic [MAX_LEVELS*DIM_W-1:0] tgt_h_all,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic [LVL_W-1:0]            cmd_level,
    output logic [DIM_W-1:0]            cmd_row_lo,
    output logic [DIM_W-1:0]            cmd_row_hi,
    output logic [DIM_W-1:0]            cmd_col_lo,
    output logic [DIM_W-1:0]            cmd_col_hi,
    input  logic                        rsp_valid,
    input  logic [DIM_W-1:0]            rsp_row,
    input  logic [DIM_W-1:0]            rsp_col,
    output logic                        done,
    output logic [DIM_W-1:0]            final_row,
    output logic [DIM_W-1:0]            final_col
);
    seq_ctl_t              ctl;
    logic [LVL_W-1:0]      nxt_level;
    logic [1:0][DIM_W-1:0] lim, seed, lo_d, hi_d, lo_q, hi_q;

    pss_fsm #(
        .MAX_LEVELS(MAX_LEVELS), .NUM_W(NUM_W), .LVL_W(LVL_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .num_levels(num_levels),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
        .cmd_valid(cmd_valid), .level(cmd_level), .nxt_level(nxt_level),
        .ctl(ctl), .done(done)
    );

    pss_level_mux #(
        .MAX_LEVELS(MAX_LEVELS), .DIM_W(DIM_W), .LVL_W(LVL_W)
    ) u_mux (
        .sel(nxt_level),
        .img_w_all(img_w_all), .img_h_all(img_h_all),
        .tgt_w_all(tgt_w_all), .tgt_h_all(tgt_h_all),
        .lim(lim)
    );

    assign seed[0] = rsp_row;
    assign seed[1] = rsp_col;

    pss_window #(.DIM_W(DIM_W), .MARGIN(MARGIN)) u_win (
        .first(ctl.first), .lim(lim), .seed(seed), .lo(lo_d), .hi(hi_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q      <= '0;
            hi_q      <= '0;
            final_row <= '0;
            final_col <= '0;
        end else begin
            if (ctl.load) begin
                lo_q <= lo_d;
                hi_q <= hi_d;
            end
            if (ctl.finish) begin
                final_row <= rsp_row;
                final_col <= rsp_col;
            end
        end
    end

    assign cmd_row_lo = lo_q[0];
    assign cmd_row_hi = hi_q[0];
    assign cmd_col_lo = lo_q[1];
    assign cmd_col_hi = hi_q[1];

    // R5: a pending command is held steady until accepted
    p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready)
        |=> (cmd_valid && $stable(cmd_level) && $stable(cmd_row_lo) &&
             $stable(cmd_row_hi) && $stable(cmd_col_lo) && $stable(cmd_col_hi)));

    // R5: an accepted command is withdrawn on the next cycle
    p_cmd_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R4: window bounds are ordered
    p_win_order_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_row_lo <= cmd_row_hi && cmd_col_lo <= cmd_col_hi));

    // R7: the final position is the last response
    p_final_pos_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (final_row == $past(rsp_row) && final_col == $past(rsp_col)
                         && !cmd_valid));

endmodule

// File: tb/sim_pyr_search_seq.sv
module sim_pyr_search_seq;
    localparam int MAXL   = 5;
    localparam int DW     = 10;
    localparam int MARGIN = 2;
    localparam int NW     = $clog2(MAXL + 1);
    localparam int LW     = (MAXL > 1) ? $clog2(MAXL) : 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, start, cmd_ready, rsp_valid;
    logic [NW-1:0] num_levels;
    logic [MAXL*DW-1:0] img_w_all, img_h_all, tgt_w_all, tgt_h_all;
    logic cmd_valid, done;
    logic [LW-1:0] cmd_level;
    logic [DW-1:0] cmd_row_lo, cmd_row_hi, cmd_col_lo, cmd_col_hi;
    logic [DW-1:0] rsp_row, rsp_col, final_row, final_col;

    int iw [MAXL];
    int ih [MAXL];
    int tw [MAXL];
    int th [MAXL];

    always_comb begin
        for (int i = 0; i < MAXL; i++) begin
            img_w_all[i*DW +: DW] = DW'(iw[i]);
            img_h_all[i*DW +: DW] = DW'(ih[i]);
            tgt_w_all[i*DW +: DW] = DW'(tw[i]);
            tgt_h_all[i*DW +: DW] = DW'(th[i]);
        end
    end

    pyr_search_seq #(.MAX_LEVELS(MAXL), .DIM_W(DW), .MARGIN(MARGIN)) u0 (
        .clk(clk), .rst(rst), .start(start), .num_levels(num_levels),
        .img_w_all(img_w_all), .img_h_all(img_h_all),
        .tgt_w_all(tgt_w_all), .tgt_h_all(tgt_h_all),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_level(cmd_level),
        .cmd_row_lo(cmd_row_lo), .cmd_row_hi(cmd_row_hi),
        .cmd_col_lo(cmd_col_lo), .cmd_col_hi(cmd_col_hi),
        .rsp_valid(rsp_valid), .rsp_row(rsp_row), .rsp_col(rsp_col),
        .done(done), .final_row(final_row), .final_col(final_col)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int f_lim(input int img, input int tgt);
        return (img >= tgt) ? img - tgt : 0;
    endfunction

    function automatic void f_win(input bit first, input int lim, input int prev,
                                  output int lo, output int hi);
        int s;
        if (first) begin
            lo = 0; hi = lim;
        end else begin
            s  = 2 * prev;
            lo = (s > MARGIN) ? s - MARGIN : 0;
            hi = (s + MARGIN < lim) ? s + MARGIN : lim;
            if (lo > hi) lo = hi;
        end
    endfunction

    task automatic cfg_pyr(input int bw, input int bh, input int btw, input int bth,
                           input bit jitter);
        for (int l = 0; l < MAXL; l++) begin
            iw[l] = (bw >> l)  + (jitter ? int'($urandom_range(1, 0)) : 0);
            ih[l] = (bh >> l)  + (jitter ? int'($urandom_range(1, 0)) : 0);
            tw[l] = (btw >> l) + (jitter ? int'($urandom_range(1, 0)) : 0);
            th[l] = (bth >> l) + (jitter ? int'($urandom_range(1, 0)) : 0);
        end
    endtask

    // run one complete sequence; mode bits pick directed stimulus
    task automatic run_seq(input int nl_raw, input bit early_rsp,
                           input bit mid_start, input bit edge_rsp);
        int eff, lr, lc, rlo, rhi, clo, chi, pr, pc, r, c, hold, gap;
        bit first;
        eff = (nl_raw == 0) ? 1 : ((nl_raw > MAXL) ? MAXL : nl_raw);
        @(negedge clk);
        start = 1'b1; num_levels = NW'(nl_raw);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9", "done after start", longint'(done), 0);
        pr = 0; pc = 0; r = 0; c = 0;
        for (int lv = eff - 1; lv >= 0; lv--) begin
            first = (lv == eff - 1);
            lr = f_lim(ih[lv], th[lv]);
            lc = f_lim(iw[lv], tw[lv]);
            f_win(first, lr, pr, rlo, rhi);
            f_win(first, lc, pc, clo, chi);
            chk(cmd_valid == 1'b1, "R5", "cmd_valid issued", longint'(cmd_valid), 1);
            chk(int'(cmd_level) == lv, first ? "R2" : "R4", "cmd_level",
                longint'(cmd_level), lv);
            chk(int'(cmd_row_lo) == rlo, first ? "R2" : "R4", "row_lo", longint'(cmd_row_lo), rlo);
            chk(int'(cmd_row_hi) == rhi, first ? "R2" : "R4", "row_hi", longint'(cmd_row_hi), rhi);
            chk(int'(cmd_col_lo) == clo, first ? "R2" : "R4", "col_lo", longint'(cmd_col_lo), clo);
            chk(int'(cmd_col_hi) == chi, first ? "R2" : "R4", "col_hi", longint'(cmd_col_hi), chi);
            hold = early_rsp ? 2 : int'($urandom_range(2, 0));
            for (int h = 0; h < hold; h++) begin
                if (early_rsp) begin
                    rsp_valid = 1'b1; rsp_row = DW'($urandom); rsp_col = DW'($urandom);
                end
                @(negedge clk);
                rsp_valid = 1'b0;
                chk(cmd_valid == 1'b1 && int'(cmd_row_lo) == rlo && int'(cmd_col_hi) == chi
                    && int'(cmd_level) == lv, early_rsp ? "R6" : "R5",
                    "command held", longint'(cmd_row_lo), rlo);
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            chk(cmd_valid == 1'b0, "R5", "cmd dropped after accept", longint'(cmd_valid), 0);
            gap = mid_start ? 2 : int'($urandom_range(2, 0));
            for (int g = 0; g < gap; g++) begin
                if (mid_start) begin
                    start = 1'b1; num_levels = NW'($urandom_range(7, 0));
                end
                @(negedge clk);
                start = 1'b0;
                chk(cmd_valid == 1'b0, mid_start ? "R8" : "R5", "no command while waiting",
                    longint'(cmd_valid), 0);
            end
            r = edge_rsp ? rhi : int'($urandom_range(rhi, rlo));
            c = edge_rsp ? chi : int'($urandom_range(chi, clo));
            rsp_valid = 1'b1; rsp_row = DW'(r); rsp_col = DW'(c);
            @(negedge clk);
            rsp_valid = 1'b0;
            pr = r; pc = c;
        end
        chk(done == 1'b1, "R7", "done raised", longint'(done), 1);
        chk(int'(final_row) == r, "R7", "final_row", longint'(final_row), r);
        chk(int'(final_col) == c, "R7", "final_col", longint'(final_col), c);
        chk(cmd_valid == 1'b0, "R7", "no command after level 0", longint'(cmd_valid), 0);
        repeat (2) @(negedge clk);
        chk(done == 1'b1, "R9", "done held", longint'(done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; cmd_ready = 1'b0; rsp_valid = 1'b0;
        num_levels = '0; rsp_row = '0; rsp_col = '0;
        cfg_pyr(64, 48, 8, 8, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1", "done", longint'(done), 0);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", longint'(cmd_valid), 0);
        chk(final_row == '0 && final_col == '0, "R1", "final pos",
            longint'(final_row), 0);

        // plain three-level walk
        run_seq(3, 1'b0, 1'b0, 1'b0);
        // R6: response strobes while command pending
        run_seq(3, 1'b1, 1'b0, 1'b0);
        // R8: start pulses during the run
        run_seq(3, 1'b0, 1'b1, 1'b0);
        // R3: target taller than image at the coarsest level
        cfg_pyr(80, 40, 16, 20, 1'b0);
        ih[2] = 10; th[2] = 12;
        run_seq(3, 1'b0, 1'b0, 1'b1);
        // R2: zero and over-range level counts
        cfg_pyr(500, 400, 40, 30, 1'b0);
        run_seq(0, 1'b0, 1'b0, 1'b0);
        run_seq(7, 1'b0, 1'b0, 1'b1);
        // R4: odd sizes with responses at the upper edge
        cfg_pyr(1001, 777, 61, 33, 1'b1);
        run_seq(5, 1'b0, 1'b0, 1'b1);

        for (int k = 0; k < 25; k++) begin
            cfg_pyr(int'($urandom_range(1000, 100)), int'($urandom_range(1000, 100)),
                    int'($urandom_range(120, 2)), int'($urandom_range(120, 2)),
                    1'b1);
            run_seq(int'($urandom_range(7, 0)), 1'($urandom_range(1, 0)),
                    1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule